// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block turns single-byte write requests from an on-chip host into a correctly timed pin sequence for an external asynchronous static RAM with a 19-bit byte address. A write is taken from a valid/ready host port. The block then drives the memory's address bus, data bus, data-driver enable, chip select, write enable and output enable. Every interval is a whole number of clock cycles, so the nanosecond limits of the memory hold for any clock period and either speed grade, both set by parameters.

The memory stores a byte only while chip select and write enable are both low. This sequencer lowers write enable first and lowers chip select last. It raises chip select first, so the data setup and hold windows are counted from that rising edge. Output enable stays high at all times, so the memory never drives the data bus against the controller.

Back-pressure rules: `req_ready` is high only when no write is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the block ignores `req_valid`, `req_addr` and `req_data`. The host learns that the memory cycle is complete from a one-cycle `wr_done` pulse. `req_ready` is high again in that same cycle.

Top module: `sram_wr_seq`

## Requirements
- R1: While reset is held and after it is released, chip select, write enable and output enable are high, the data driver is off, `wr_done` is low and `req_ready` is high.
- R2: In the cycle after an accepting edge, `sram_addr` and `sram_dq_out` show the accepted address and data. They keep those values until the next accepting edge.
- R3: Write enable goes low in the cycle after acceptance. The data driver stays off for F = max(1, ceil(20 ns / period)) cycles. Then the data driver turns on and chip select goes low on the same edge.
- R4: Chip select stays low for C cycles, where C = max(ceil(tCS/period), ceil(tDS/period), ceil(tWE/period) - F, 1).
- R5: Chip select rises while write enable is still low, so chip select ends the write. One cycle later, write enable rises and the data driver turns off on the same edge.
- R6: Output enable is high in every cycle.
- R7: `wr_done` is high for exactly one cycle. It rises T = max(ceil(tWC/period), F + C + 1) cycles after the accepting edge.
- R8: `req_ready` is low from the accepting edge until `wr_done` rises. Valid requests offered while it is low are not taken and do not change any pin. A request held valid is taken on the edge that ends the `wr_done` cycle.
- R9: With the fast grade, tWC = 55, tCS = 45, tDS = 25 and tWE = 40 ns. With the slow grade, these are 70, 60, 30 and 50 ns. The period and the grade are parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host offers a write |
| req_ready | output | 1 | Sequencer idle, may take a write |
| req_addr | input | ADDR_W | Byte address of the write |
| req_data | input | DATA_W | Byte to store |
| wr_done | output | 1 | One-cycle pulse: memory cycle complete |
| sram_addr | output | ADDR_W | Memory address bus |
| sram_dq_out | output | DATA_W | Memory data bus, outbound value |
| sram_dq_oe | output | 1 | Data bus driver enable |
| sram_cs_n | output | 1 | Memory chip select, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |

## Verification
Two events can fall on the same edge, and the bench provokes both collisions. On the edge where write enable rises and the driver turns off, `wr_done` is also set and `req_ready` returns. On the edge that ends that cycle, a held request is taken at once, so release, completion and a new address follow each other with no idle gap. The bench holds `req_valid` high for long stretches to get this back-to-back traffic, and toggles it during busy periods with a changing payload. A behavioural model is stepped every cycle and compares every pin for two builds: fast grade at a 10 ns period and slow grade at a 7 ns period.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  localparam int FLOAT_NS = 20;

  function automatic int ceil_div(input int ns, input int period);
    return (ns + period - 1) / period;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int cycle_ns(input int slow);
    return (slow != 0) ? 70 : 55;
  endfunction

  function automatic int cs_ns(input int slow);
    return (slow != 0) ? 60 : 45;
  endfunction

  function automatic int setup_ns(input int slow);
    return (slow != 0) ? 30 : 25;
  endfunction

  function automatic int we_ns(input int slow);
    return (slow != 0) ? 50 : 40;
  endfunction

endpackage

// File: rtl/sram_wr_timer.sv
module sram_wr_timer #(
  parameter int DRIVE_AT   = 2,
  parameter int CS_END_AT  = 7,
  parameter int RELEASE_AT = 8,
  parameter int DONE_AT    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic at_drive,
  output logic at_cs_end,
  output logic at_release,
  output logic done_pulse
);
  localparam int CW = $clog2(DONE_AT + 1);
  localparam logic [CW-1:0] K_DRIVE = CW'(DRIVE_AT);
  localparam logic [CW-1:0] K_CSEND = CW'(CS_END_AT);
  localparam logic [CW-1:0] K_REL   = CW'(RELEASE_AT);
  localparam logic [CW-1:0] K_DONE  = CW'(DONE_AT);

  logic [CW-1:0] cnt;
  logic [CW-1:0] nxt;

  assign nxt = cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      cnt        <= '0;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= nxt;
        if (nxt == K_DONE) begin
          busy       <= 1'b0;
          done_pulse <= 1'b1;
        end
      end
    end
  end

  assign at_drive   = busy && (nxt == K_DRIVE);
  assign at_cs_end  = busy && (nxt == K_CSEND);
  assign at_release = busy && (nxt == K_REL);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  assert_done_on_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_pulse);

endmodule

// File: rtl/sram_wr_pins.sv
module sram_wr_pins #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int CS_CYC = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              at_drive,
  input  logic              at_cs_end,
  input  logic              at_release,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic              sram_oe_n
);
  localparam int CCW = $clog2(CS_CYC + 2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sram_addr   <= '0;
      sram_dq_out <= '0;
      sram_dq_oe  <= 1'b0;
      sram_cs_n   <= 1'b1;
      sram_we_n   <= 1'b1;
    end else begin
      if (load) begin
        sram_addr   <= addr_in;
        sram_dq_out <= data_in;
        sram_we_n   <= 1'b0;
      end
      if (at_drive) begin
        sram_dq_oe <= 1'b1;
        sram_cs_n  <= 1'b0;
      end
      if (at_cs_end) sram_cs_n <= 1'b1;
      if (at_release) begin
        sram_we_n  <= 1'b1;
        sram_dq_oe <= 1'b0;
      end
    end
  end

  assign sram_oe_n = 1'b1;

  // Checker counter: length of the current chip-select low phase.
  logic [CCW-1:0] cs_low_len;
  always_ff @(posedge clk) begin
    if (!rst_n) cs_low_len <= '0;
    else if (sram_cs_n) cs_low_len <= '0;
    else if (cs_low_len != {CCW{1'b1}}) cs_low_len <= cs_low_len + 1'b1;
  end

  assert_cs_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_cs_n) |-> (cs_low_len >= CCW'(CS_CYC)));

  assert_cs_needs_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_cs_n |-> (sram_dq_oe && !sram_we_n));

  assert_drive_under_we_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> !sram_we_n);

  assert_cs_ends_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_cs_n) |-> !sram_we_n);

  assert_we_after_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> $past($rose(sram_cs_n)));

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 8,
  parameter int CLK_NS     = 10,
  parameter int SLOW_GRADE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              wr_done,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic              sram_oe_n
);
  localparam int FLOAT_CYC = imax(1, ceil_div(FLOAT_NS, CLK_NS));
  localparam int CS_CYC = imax(imax(ceil_div(cs_ns(SLOW_GRADE), CLK_NS),
                                    ceil_div(setup_ns(SLOW_GRADE), CLK_NS)),
                               imax(ceil_div(we_ns(SLOW_GRADE), CLK_NS) - FLOAT_CYC, 1));
  localparam int REL_AT  = FLOAT_CYC + CS_CYC + 1;
  localparam int DONE_AT = imax(ceil_div(cycle_ns(SLOW_GRADE), CLK_NS), REL_AT);

  logic busy, accept, at_drive, at_cs_end, at_release;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  sram_wr_timer #(
    .DRIVE_AT  (FLOAT_CYC),
    .CS_END_AT (FLOAT_CYC + CS_CYC),
    .RELEASE_AT(REL_AT),
    .DONE_AT   (DONE_AT)
  ) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .busy      (busy),
    .at_drive  (at_drive),
    .at_cs_end (at_cs_end),
    .at_release(at_release),
    .done_pulse(wr_done)
  );

  sram_wr_pins #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CS_CYC(CS_CYC)
  ) pins_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .addr_in    (req_addr),
    .data_in    (req_data),
    .at_drive   (at_drive),
    .at_cs_end  (at_cs_end),
    .at_release (at_release),
    .sram_addr  (sram_addr),
    .sram_dq_out(sram_dq_out),
    .sram_dq_oe (sram_dq_oe),
    .sram_cs_n  (sram_cs_n),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n)
  );

  assert_pins_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(sram_addr) && $stable(sram_dq_out)));

  assert_ready_bus_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_cs_n && sram_we_n && !sram_dq_oe));

endmodule

// File: tb/sram_wr_seq_tb.sv
module sram_wr_lane #(
  parameter int    CLK_NS = 10,
  parameter int    SLOW   = 0,
  parameter string TAG    = "lane"
) (
  input  logic clk,
  input  logic rst_n,
  output int   n_chk,
  output int   n_fail,
  output logic finished
);
  localparam int NCYC = 400;

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  // Expected cycle counts derived from the requirement limits (R3, R4, R7, R9).
  localparam int E_F   = (cdiv(20, CLK_NS) < 1) ? 1 : cdiv(20, CLK_NS);
  localparam int E_CS  = cdiv(SLOW ? 60 : 45, CLK_NS);
  localparam int E_DS  = cdiv(SLOW ? 30 : 25, CLK_NS);
  localparam int E_WE  = cdiv(SLOW ? 50 : 40, CLK_NS) - E_F;
  localparam int E_C0  = (E_CS > E_DS) ? E_CS : E_DS;
  localparam int E_C1  = (E_WE > 1) ? E_WE : 1;
  localparam int E_C   = (E_C0 > E_C1) ? E_C0 : E_C1;
  localparam int E_REL = E_F + E_C + 1;
  localparam int E_WC  = cdiv(SLOW ? 70 : 55, CLK_NS);
  localparam int E_T   = (E_WC > E_REL) ? E_WC : E_REL;

  logic        v;
  logic [18:0] a;
  logic [7:0]  d;
  logic        rdy, done, dq_oe, cs_n, we_n, oe_n;
  logic [18:0] p_addr;
  logic [7:0]  p_data;

  sram_wr_seq #(.ADDR_W(19), .DATA_W(8), .CLK_NS(CLK_NS), .SLOW_GRADE(SLOW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(v), .req_ready(rdy),
    .req_addr(a), .req_data(d), .wr_done(done),
    .sram_addr(p_addr), .sram_dq_out(p_data), .sram_dq_oe(dq_oe),
    .sram_cs_n(cs_n), .sram_we_n(we_n), .sram_oe_n(oe_n)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s at %0t: actual %0h expected %0h", TAG, req, $time, act, exp);
    end
  endtask

  bit          m_busy, m_done;
  int          m_k;
  logic [18:0] m_addr;
  logic [7:0]  m_data;

  initial begin
    n_chk = 0; n_fail = 0; finished = 1'b0;
    v = 1'b0; a = '0; d = '0;
    m_busy = 0; m_done = 0; m_k = 0; m_addr = '0; m_data = '0;
    @(negedge clk);
    @(negedge clk);
    check("R1 cs_n in reset", int'(cs_n), 1);
    check("R1 we_n in reset", int'(we_n), 1);
    check("R1 oe_n in reset", int'(oe_n), 1);
    check("R1 dq_oe in reset", int'(dq_oe), 0);
    check("R1 ready in reset", int'(rdy), 1);
    check("R1 done in reset", int'(done), 0);
    wait (rst_n);
    for (int i = 0; i < NCYC; i++) begin
      @(negedge clk);
      check("R5 we_n", int'(we_n), (m_busy && m_k < E_REL) ? 0 : 1);
      check("R4 cs_n", int'(cs_n), (m_busy && m_k >= E_F && m_k < E_F + E_C) ? 0 : 1);
      check("R3 dq_oe", int'(dq_oe), (m_busy && m_k >= E_F && m_k < E_REL) ? 1 : 0);
      check("R6 oe_n", int'(oe_n), 1);
      check("R8 ready", int'(rdy), m_busy ? 0 : 1);
      check("R7 done", int'(done), int'(m_done));
      check("R2 addr", int'(p_addr), int'(m_addr));
      check("R2 data", int'(p_data), int'(m_data));
      // New stimulus for the coming edge
      if (i < 80)       v = ((i % 17) == 3);
      else if (i < 240) v = 1'b1;
      else              v = ((i % 3) != 0);
      a = 19'(i * 7919 + 12345);
      d = 8'(i * 37 + 5);
      // Model step for the coming edge
      m_done = 0;
      if (!m_busy) begin
        if (v) begin
          m_busy = 1; m_k = 0; m_addr = a; m_data = d;
        end
      end else begin
        m_k++;
        if (m_k == E_T) begin
          m_busy = 0; m_done = 1;
        end
      end
    end
    finished = 1'b1;
  end
endmodule

module sram_wr_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   c0, f0, c1, f1;
  logic d0, d1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sram_wr_lane #(.CLK_NS(10), .SLOW(0), .TAG("fast")) lane_fast (
    .clk(clk), .rst_n(rst_n), .n_chk(c0), .n_fail(f0), .finished(d0));

  sram_wr_lane #(.CLK_NS(7), .SLOW(1), .TAG("R9 slow")) lane_slow (
    .clk(clk), .rst_n(rst_n), .n_chk(c1), .n_fail(f1), .finished(d1));

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  end

  initial begin
    int cyc;
    int wd;
    cyc = 0;
    wd  = 0;
    while (!(d0 === 1'b1 && d1 === 1'b1) && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!(d0 === 1'b1 && d1 === 1'b1)) begin
      wd = 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", c0 + c1 + wd, f0 + f1 + wd);
    $finish;
  end
endmodule